// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing of a video raster from a single pixel clock. Software programs it through a small register write port: one pair of registers per axis sets the total count and the visible extent, another pair sets where the sync pulse starts and how long it lasts, and a control word holds the run enable, the display-plane request, the sync polarities and a pixel-clock phase select. The outputs are horizontal and vertical sync, a display-active flag and the current pixel column and line.

Totals, visible extents and sync starts are stored as the wanted value minus one, while sync lengths are stored as plain counts. A change to the display-plane request is not applied at once. It is latched into the live plane state on the first pixel of the next vertical sync pulse. Reading the control word returns that live state, so the read value trails the written one until the pulse arrives. Clearing the run enable parks both counters at zero and forces every sync output to its idle level.

Top module: `disp_timing_gen`

## Requirements
- R1: Register map by `wr_addr`/`rd_addr`: 0 control, 1 horizontal timing, 2 horizontal sync, 3 vertical timing, 4 vertical sync. A timing register holds total minus one in bits [27:16] and visible extent minus one in bits [11:0]. A sync register holds the pulse length as a plain count in bits [27:16] and the start minus one in bits [11:0].
- R2: While running, `pix_x` counts up by one per clock from 0 to the stored horizontal total and then returns to 0.
- R3: `pix_y` advances by one only on the clock where `pix_x` returns to 0. It returns to 0 after the line equal to the stored vertical total.
- R4: The horizontal pulse is active while `pix_x` is at least the stored start and less than the stored start plus the length. A length of 0 gives no pulse.
- R5: The vertical pulse follows the same rule using `pix_y`, the vertical start and the vertical length.
- R6: Control bit 2 sets the horizontal sync polarity and bit 3 sets the vertical sync polarity. With the bit at 0 the sync is high when active; with the bit at 1 it is low when active. The idle level is the opposite of the active level.
- R7: Control bit 0 is the run enable. While it is 0, both counters read 0, both syncs sit at their idle level and `de_o` is low.
- R8: `de_o` is high exactly when the block is running, the live plane state is on, `pix_x` is at most the stored horizontal extent and `pix_y` is at most the stored vertical extent.
- R9: Control bit 1 is the plane request. The live plane state takes the request value at the clock edge where the block is running, `pix_x` is 0, `pix_y` equals the stored vertical start and the vertical length is nonzero. Control readback bit 1 shows the live state.
- R10: Control bit 14 is driven on `clk_phase_o`.
- R11: After reset, every register and the live plane state are 0, both counters are 0 and both syncs are low.
- R12: Reading addresses 1 to 4 returns the written fields. Reading address 0 returns bits 0, 2, 3 and 14 as written. Other bits and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Display-active flag |
| pix_x | output | 12 | Current pixel column |
| pix_y | output | 12 | Current line |
| clk_phase_o | output | 1 | Pixel-clock phase select |

## Verification
The bench builds the block with its default parameters: 12-bit counters and a 32-bit register word. It programs small frames, with totals of a few dozen pixels and lines, so that many complete frames, sync pulses and plane commits happen within the run. The random frames cover zero-length pulses, pulses that run past the total, and both polarities. The directed cases cover the plane request trailing on readback and the parking of the counters when the run enable is cleared.

// File: rtl/disp_timing_pkg.sv
package disp_timing_pkg;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_HTIM = 3'd1,
    A_HSYN = 3'd2,
    A_VTIM = 3'd3,
    A_VSYN = 3'd4
  } dtg_addr_e;

  localparam int B_RUN    = 0;
  localparam int B_PLANE  = 1;
  localparam int B_HPOL   = 2;
  localparam int B_VPOL   = 3;
  localparam int B_CLKPH  = 14;
  localparam int HI_LSB   = 16;
  localparam int AX_H     = 0;
  localparam int AX_V     = 1;

  typedef struct packed {
    logic clk_ph;
    logic vpol;
    logic hpol;
    logic plane_req;
    logic run;
  } dtg_ctrl_t;

  // Pulse window test, widened by one bit so start + length cannot wrap.
  function automatic logic in_window(input logic [15:0] cnt,
                                     input logic [15:0] start,
                                     input logic [15:0] len);
    logic [16:0] stop;
    stop = {1'b0, start} + {1'b0, len};
    return (len != 16'd0) && (cnt >= start) && ({1'b0, cnt} < stop);
  endfunction

endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import disp_timing_pkg::*;
#(
  parameter int CW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          commit_evt,
  output dtg_ctrl_t     ctrl_q,
  output logic          plane_on,
  output logic [CW-1:0] tot   [2],
  output logic [CW-1:0] dend  [2],
  output logic [CW-1:0] sst   [2],
  output logic [CW-1:0] slen  [2]
);

  localparam int HI_TOP = HI_LSB + CW;

  logic wr_ctrl;
  logic wr_tim [2];
  logic wr_syn [2];

  assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);
  assign wr_tim[0] = wr_en && (wr_addr == A_HTIM);
  assign wr_tim[1] = wr_en && (wr_addr == A_VTIM);
  assign wr_syn[0] = wr_en && (wr_addr == A_HSYN);
  assign wr_syn[1] = wr_en && (wr_addr == A_VSYN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.run       <= wr_data[B_RUN];
      ctrl_q.plane_req <= wr_data[B_PLANE];
      ctrl_q.hpol      <= wr_data[B_HPOL];
      ctrl_q.vpol      <= wr_data[B_VPOL];
      ctrl_q.clk_ph    <= wr_data[B_CLKPH];
    end
  end

  for (genvar ax = 0; ax < 2; ax++) begin : g_axis
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tot[ax]  <= '0;
        dend[ax] <= '0;
      end else if (wr_tim[ax]) begin
        tot[ax]  <= wr_data[HI_LSB +: CW];
        dend[ax] <= wr_data[0 +: CW];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sst[ax]  <= '0;
        slen[ax] <= '0;
      end else if (wr_syn[ax]) begin
        slen[ax] <= wr_data[HI_LSB +: CW];
        sst[ax]  <= wr_data[0 +: CW];
      end
    end
  end

  // The plane request only reaches the live state on the vertical pulse start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          plane_on <= 1'b0;
    else if (commit_evt) plane_on <= ctrl_q.plane_req;
  end

  function automatic logic [DW-1:0] pair(input logic [CW-1:0] hi, input logic [CW-1:0] lo);
    logic [DW-1:0] w;
    w = '0;
    w[HI_LSB +: CW] = hi;
    w[0 +: CW]      = lo;
    return w;
  endfunction

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[B_RUN]   = ctrl_q.run;
        rd_data[B_PLANE] = plane_on;
        rd_data[B_HPOL]  = ctrl_q.hpol;
        rd_data[B_VPOL]  = ctrl_q.vpol;
        rd_data[B_CLKPH] = ctrl_q.clk_ph;
      end
      A_HTIM:  rd_data = pair(tot[0], dend[0]);
      A_HSYN:  rd_data = pair(slen[0], sst[0]);
      A_VTIM:  rd_data = pair(tot[1], dend[1]);
      A_VSYN:  rd_data = pair(slen[1], sst[1]);
      default: rd_data = '0;
    endcase
  end

  initial begin
    if (HI_TOP > DW) $error("register word too narrow for counter width");
  end

  // R9: live plane state moves only on a commit event
  p_plane_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (plane_on != $past(plane_on)) |-> $past(commit_evt));

  // R9: on a commit the live state takes the request
  p_plane_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (plane_on == $past(ctrl_q.plane_req)));

endmodule

// File: rtl/dtg_counters.sv
module dtg_counters #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] htot,
  input  logic [CW-1:0] vtot,
  output logic [CW-1:0] hcnt,
  output logic [CW-1:0] vcnt,
  output logic          line_wrap
);

  logic frame_wrap;

  assign line_wrap  = run && (hcnt >= htot);
  assign frame_wrap = line_wrap && (vcnt >= vtot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (!run) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (line_wrap) begin
      hcnt <= '0;
      vcnt <= frame_wrap ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  // R2: column steps by one inside a line
  p_hstep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hcnt < htot) |=> (hcnt == CW'($past(hcnt) + 1'b1)));

  // R2: column returns to zero after the total
  p_hwrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hcnt >= htot) |=> (hcnt == '0));

  // R3: line holds while the column has not wrapped
  p_vhold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hcnt < htot) |=> $stable(vcnt));

  // R3: line advances on a column wrap below the vertical total
  p_vstep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hcnt >= htot && vcnt < vtot) |=> (vcnt == CW'($past(vcnt) + 1'b1)));

  // R7: stopped counters park at zero
  p_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (hcnt == '0 && vcnt == '0));

endmodule

// File: rtl/dtg_sync.sv
module dtg_sync
  import disp_timing_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] start,
  input  logic [CW-1:0] len,
  input  logic          pol_low,
  output logic          active,
  output logic          sync_o
);

  assign active = run && in_window(16'(cnt), 16'(start), 16'(len));
  assign sync_o = active ^ pol_low;

  // R7: stopped block holds the idle level
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (sync_o == pol_low));

  // R4: zero length never produces a pulse
  p_zero_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (len == '0) |-> (sync_o == pol_low));

  // R4: the count below the start is never inside the pulse
  p_before_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < start) |-> !active);

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import disp_timing_pkg::*;
#(
  parameter int CW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] pix_y,
  output logic          clk_phase_o
);

  dtg_ctrl_t     ctrl_q;
  logic          plane_on;
  logic [CW-1:0] tot  [2];
  logic [CW-1:0] dend [2];
  logic [CW-1:0] sst  [2];
  logic [CW-1:0] slen [2];
  logic [CW-1:0] cnt  [2];
  logic          pol  [2];
  logic          act  [2];
  logic          sync [2];
  logic          line_wrap;
  logic          commit_evt;
  logic          in_area;

  dtg_regs #(.CW(CW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .commit_evt (commit_evt),
    .ctrl_q     (ctrl_q),
    .plane_on   (plane_on),
    .tot        (tot),
    .dend       (dend),
    .sst        (sst),
    .slen       (slen)
  );

  dtg_counters #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctrl_q.run),
    .htot      (tot[AX_H]),
    .vtot      (tot[AX_V]),
    .hcnt      (cnt[AX_H]),
    .vcnt      (cnt[AX_V]),
    .line_wrap (line_wrap)
  );

  assign pol[AX_H] = ctrl_q.hpol;
  assign pol[AX_V] = ctrl_q.vpol;

  for (genvar ax = 0; ax < 2; ax++) begin : g_sync
    dtg_sync #(.CW(CW)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl_q.run),
      .cnt     (cnt[ax]),
      .start   (sst[ax]),
      .len     (slen[ax]),
      .pol_low (pol[ax]),
      .active  (act[ax]),
      .sync_o  (sync[ax])
    );
  end

  // First pixel of the vertical pulse: the one point where the plane may change.
  assign commit_evt = ctrl_q.run && (cnt[AX_H] == '0) &&
                      (cnt[AX_V] == sst[AX_V]) && (slen[AX_V] != '0);

  assign in_area     = (cnt[AX_H] <= dend[AX_H]) && (cnt[AX_V] <= dend[AX_V]);
  assign de_o        = ctrl_q.run && plane_on && in_area;
  assign hsync_o     = sync[AX_H];
  assign vsync_o     = sync[AX_V];
  assign pix_x       = cnt[AX_H];
  assign pix_y       = cnt[AX_V];
  assign clk_phase_o = ctrl_q.clk_ph;

  // R9: a commit always coincides with the vertical pulse being active
  p_commit_in_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |-> act[AX_V]);

  // R8: display-active never shows without the live plane
  p_de_plane_r8: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> (plane_on && ctrl_q.run));

  // R3: a line change is always preceded by a column wrap
  p_line_on_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.run && !line_wrap) |=> (pix_y == $past(pix_y)));

endmodule

// File: tb/disp_timing_gen_bench.sv
module disp_timing_gen_bench;
  localparam int CW = 12;
  localparam int DW = 32;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [2:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          hsync_o, vsync_o, de_o, clk_phase_o;
  logic [CW-1:0] pix_x, pix_y;

  int checks = 0;
  int errors = 0;
  bit live_chk = 1'b0;

  // Reference state, kept from the requirements.
  int m_h, m_v;
  int m_tot [2], m_end [2], m_st [2], m_len [2];
  bit m_run, m_req, m_plane, m_hp, m_vp, m_cp;

  disp_timing_gen #(.CW(CW), .DW(DW)) u_disp_timing_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .pix_x(pix_x), .pix_y(pix_y), .clk_phase_o(clk_phase_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit f_sync(int c, int st, int len, bit pol_low, bit run);
    bit on;
    on = run && (len > 0) && (c >= st) && ((c - st) < len);
    return on ^ pol_low;
  endfunction

  function automatic logic [31:0] f_pair(int hi, int lo);
    return (32'(hi) << 16) | 32'(lo);
  endfunction

  function automatic logic [31:0] f_read(int a);
    case (a)
      0: return 32'(m_run) | (32'(m_plane) << 1) | (32'(m_hp) << 2) |
                (32'(m_vp) << 3) | (32'(m_cp) << 14);
      1: return f_pair(m_tot[0], m_end[0]);
      2: return f_pair(m_len[0], m_st[0]);
      3: return f_pair(m_tot[1], m_end[1]);
      4: return f_pair(m_len[1], m_st[1]);
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_h = 0; m_v = 0; m_run = 0; m_req = 0; m_plane = 0;
      m_hp = 0; m_vp = 0; m_cp = 0;
      for (int i = 0; i < 2; i++) begin
        m_tot[i] = 0; m_end[i] = 0; m_st[i] = 0; m_len[i] = 0;
      end
    end else begin
      bit commit;
      commit = m_run && m_h == 0 && m_v == m_st[1] && m_len[1] != 0;
      if (!m_run) begin
        m_h = 0; m_v = 0;
      end else if (m_h >= m_tot[0]) begin
        m_h = 0;
        m_v = (m_v >= m_tot[1]) ? 0 : m_v + 1;
      end else begin
        m_h = m_h + 1;
      end
      if (commit) m_plane = m_req;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin
            m_run = wr_data[0]; m_req = wr_data[1]; m_hp = wr_data[2];
            m_vp = wr_data[3]; m_cp = wr_data[14];
          end
          3'd1: begin m_tot[0] = int'(wr_data[27:16]); m_end[0] = int'(wr_data[11:0]); end
          3'd2: begin m_len[0] = int'(wr_data[27:16]); m_st[0]  = int'(wr_data[11:0]); end
          3'd3: begin m_tot[1] = int'(wr_data[27:16]); m_end[1] = int'(wr_data[11:0]); end
          3'd4: begin m_len[1] = int'(wr_data[27:16]); m_st[1]  = int'(wr_data[11:0]); end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison, sampled well after the edge.
  always @(posedge clk) begin
    #(CLK_PERIOD*3/10);
    if (live_chk && rst_n) begin
      bit de_exp;
      de_exp = m_run && m_plane && m_h <= m_end[0] && m_v <= m_end[1];
      chk("R2 pix_x", 32'(pix_x), 32'(m_h));
      chk("R3 pix_y", 32'(pix_y), 32'(m_v));
      chk("R4/R6 hsync", 32'(hsync_o), 32'(f_sync(m_h, m_st[0], m_len[0], m_hp, m_run)));
      chk("R5/R6 vsync", 32'(vsync_o), 32'(f_sync(m_v, m_st[1], m_len[1], m_vp, m_run)));
      chk("R8 de", 32'(de_o), 32'(de_exp));
      chk("R12 readback", rd_data, f_read(int'(rd_addr)));
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = 3'(a);
    #1 d = rd_data;
  endtask

  // Desired counts in, stored values written as the R1 encoding.
  task automatic setup(int ht, int he, int hs, int hl, int vt, int ve, int vs, int vl,
                       logic [31:0] ctrl);
    wr(0, ctrl & ~32'd1);
    wr(1, f_pair(ht - 1, he - 1));
    wr(2, f_pair(hl, hs - 1));
    wr(3, f_pair(vt - 1, ve - 1));
    wr(4, f_pair(vl, vs - 1));
    wr(0, ctrl);
  endtask

  task automatic run_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int hseen;
    void'($urandom(32'h1f2e3d4c));
    run_cycles(4);
    rst_n = 1'b1;
    run_cycles(2);

    // R11: reset state
    chk("R11 hsync", 32'(hsync_o), 32'd0);
    chk("R11 vsync", 32'(vsync_o), 32'd0);
    chk("R11 de", 32'(de_o), 32'd0);
    chk("R11 pix", 32'({pix_x, pix_y}), 32'd0);
    for (int a = 0; a < 5; a++) begin
      rd(a, d);
      chk("R11 register", d, 32'd0);
    end
    rd(7, d);
    chk("R12 unused address", d, 32'd0);

    live_chk = 1'b1;
    // Frame A: 20 x 10, plane requested with the start
    setup(20, 16, 17, 2, 10, 8, 9, 1, 32'h3);
    rd(0, d);
    chk("R9 plane trails write", d & 32'h2, 32'h0);
    rd(1, d);
    chk("R1 htiming fields", d, f_pair(19, 15));
    rd(4, d);
    chk("R1 vsync fields", d, f_pair(1, 8));
    rd(0, d);
    run_cycles(420);
    rd(0, d);
    chk("R9 plane applied", d & 32'h2, 32'h2);

    // R6 / R10: inverted polarities and clock phase
    wr(0, 32'h400F);
    run_cycles(3);
    chk("R10 clk_phase", 32'(clk_phase_o), 32'd1);
    rd(0, d);
    run_cycles(250);

    // R9: turning the plane off waits for the pulse
    wr(0, 32'h0001);
    rd(0, d);
    chk("R9 off trails write", d & 32'h2, 32'h2);
    chk("R10 clk_phase cleared", 32'(clk_phase_o), 32'd0);
    run_cycles(420);
    rd(0, d);
    chk("R9 off applied", d & 32'h2, 32'h0);

    // R4: zero-length horizontal pulse
    setup(16, 10, 12, 0, 8, 6, 7, 2, 32'h3);
    rd(0, d);
    hseen = 0;
    repeat (300) begin
      @(negedge clk);
      if (hsync_o) hseen++;
    end
    chk("R4 zero length", 32'(hseen), 32'd0);

    // R7: clearing run parks everything
    wr(0, 32'h0006);
    run_cycles(3);
    chk("R7 pix parked", 32'({pix_x, pix_y}), 32'd0);
    chk("R7 hsync idle", 32'(hsync_o), 32'd1);
    chk("R7 vsync idle", 32'(vsync_o), 32'd0);
    chk("R7 de low", 32'(de_o), 32'd0);

    // Random frames and control words
    for (int k = 0; k < 8; k++) begin
      int ht, he, hs, hl, vt, ve, vs, vl;
      logic [31:0] c;
      ht = 8 + int'($urandom % 30);
      he = 1 + int'($urandom % (ht - 2));
      hs = he + 1 + int'($urandom % (ht - he));
      hl = int'($urandom % 5);
      vt = 4 + int'($urandom % 20);
      ve = 1 + int'($urandom % (vt - 2));
      vs = ve + 1 + int'($urandom % (vt - ve));
      vl = int'($urandom % 3);
      c = 32'h1 | ($urandom & 32'h400E);
      setup(ht, he, hs, hl, vt, ve, vs, vl, c);
      rd(int'($urandom % 6), d);
      run_cycles(2 * ht * vt + 8);
    end

    live_chk = 1'b0;
    run_cycles(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule